// File: doc/BRIEF.md
# Parallel Dither Absolute-Difference Scoring Element

This block scores one template pose against an image chip at eleven horizontal dither offsets in a single pass. A template sample and a chip sample arrive together on each accepted beat, typically from the two read ports of a dual-port memory. The template sample goes to all eleven scoring lanes at once. The chip sample moves through a ten-register delay line, so lane k compares the current template sample with the chip sample from k beats earlier. Each lane adds up the absolute differences. No multiplier is used.

All lanes share one clock and one control path, so they start, clear and finish together. Every pixel position is processed, whether the pixel is valid or not. When the pass ends, the element presents all eleven scores together with the dither row index that was captured at start. A controller repeats the pass once per dither row. Eleven passes cover an 11x11 low-resolution grid. For a 7x7 high-resolution grid, the controller masks four lanes and runs seven passes.

Top module: `mad_dither_element`

## Requirements
- R1: After reset, `scores_valid` is 0, `score_row` is 0, every lane is enabled and every score reads 0.
- R2: For the beats n = 0..N-1 of a pass, lane k reports the sum of |T[n] - C[n-k]|, where C[j] is taken as 0 for j < 0.
- R3: `tmpl_px` and `chip_px` are 12-bit two's-complement values, so a single difference can reach 4095 (2047 against -2048).
- R4: A lane score saturates at 2^24-1 (all ones in 24 bits) and never wraps to a smaller value.
- R5: `scores_valid` is high for exactly one cycle. It rises in the second cycle after the clock edge that accepts the beat carrying `last_pixel`.
- R6: `lane_en` is captured when `start` is high. Bit k = 1 enables lane k. A disabled lane reports all ones for the whole pass.
- R7: `row_idx` is captured when `start` is high and appears on `score_row` until the next start.
- R8: `start` clears all eleven accumulators and the chip delay line together, including in the middle of a pass. A beat presented in the same cycle as `start` is discarded.
- R9: Cycles with `pixel_valid` low do not change the result. The delay line and the accumulators advance only on accepted beats.
- R10: After the pulse, the scores keep their final values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a pass: clears lanes, captures row and lane enables |
| pixel_valid | input | 1 | A template/chip pair is present this cycle |
| last_pixel | input | 1 | Marks the final beat of the pass (used together with pixel_valid) |
| tmpl_px | input | 12 | Template sample, two's complement |
| chip_px | input | 12 | Chip sample, two's complement |
| row_idx | input | 4 | Dither row index for this pass |
| lane_en | input | 11 | Per-lane enable, bit k for offset k |
| scores_valid | output | 1 | One-cycle pulse when the pass scores are final |
| scores | output | 264 | Eleven 24-bit scores, lane k at bits [24k+23:24k] |
| score_row | output | 4 | Row index captured at start |

## Verification
A corrupted delay-line register affects only the lanes at or beyond that tap. Those lanes drift from their expected sums, and the bench catches this at the next pulse. Lane 0 stays correct, which narrows the fault to the delay line. An accumulator that wraps instead of saturating shows up as a score far below the maximum on the long saturation pass. The checker sees the drop on the very cycle it happens. A control path that loses `last_pixel` or delays it by one stage moves the pulse off its fixed two-cycle slot, which shows up as a missing or extra `scores_valid` cycle. A lane left uncleared by `start` carries the score of the abandoned pass into the next pulse, and the checker flags it one cycle after `start`.

// File: rtl/mad_pkg.sv
package mad_pkg;

  // Control bits carried one stage behind the input beat.
  typedef struct packed {
    logic beat;
    logic last;
  } ctl_t;

endpackage

// File: rtl/mad_chip_delay.sv
module mad_chip_delay #(
  parameter int PIX_W = 12,
  parameter int DEPTH = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          shift,
  input  logic [PIX_W-1:0]              din,
  output logic [DEPTH:0][PIX_W-1:0]     taps
);

  logic [DEPTH-1:0][PIX_W-1:0] stage_q;

  assign taps[0] = din;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [PIX_W-1:0] src;
    if (i == 0) begin : g_head
      assign src = din;
    end else begin : g_body
      assign src = stage_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[i] <= '0;
      else if (clear)  stage_q[i] <= '0;
      else if (shift)  stage_q[i] <= src;
    end

    assign taps[i+1] = stage_q[i];
  end

endmodule

// File: rtl/mad_lane.sv
module mad_lane #(
  parameter int PIX_W = 12,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic             upd,
  input  logic [PIX_W-1:0] tmpl,
  input  logic [PIX_W-1:0] chip,
  output logic [ACC_W-1:0] acc
);

  localparam int MAG_W = PIX_W + 1;

  // Magnitude of a signed difference, one bit wider than the operands.
  function automatic logic [MAG_W-1:0] abs_gap(input logic [PIX_W-1:0] a,
                                               input logic [PIX_W-1:0] b);
    logic signed [MAG_W-1:0] d;
    d = signed'({a[PIX_W-1], a}) - signed'({b[PIX_W-1], b});
    return d[MAG_W-1] ? MAG_W'(-d) : MAG_W'(d);
  endfunction

  // Add with clamp to all ones on carry out.
  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                               input logic [MAG_W-1:0] b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + {{(ACC_W-PIX_W){1'b0}}, b};
    return s[ACC_W] ? '1 : s[ACC_W-1:0];
  endfunction

  logic [MAG_W-1:0] diff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    diff_q <= '0;
    else if (load) diff_q <= abs_gap(tmpl, chip);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (upd)   acc <= sat_add(acc, diff_q);
  end

endmodule

// File: rtl/mad_dither_element.sv
module mad_dither_element #(
  parameter int LANES = 11,
  parameter int PIX_W = 12,
  parameter int ACC_W = 24,
  parameter int ROW_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   pixel_valid,
  input  logic                   last_pixel,
  input  logic [PIX_W-1:0]       tmpl_px,
  input  logic [PIX_W-1:0]       chip_px,
  input  logic [ROW_W-1:0]       row_idx,
  input  logic [LANES-1:0]       lane_en,
  output logic                   scores_valid,
  output logic [LANES*ACC_W-1:0] scores,
  output logic [ROW_W-1:0]       score_row
);
  import mad_pkg::*;

  localparam int TAPS = LANES - 1;

  // Named internal events
  logic                        beat_s0;
  logic                        upd_s1;
  logic                        pass_done;
  ctl_t                        ctl_s1;
  logic [TAPS:0][PIX_W-1:0]    chip_tap;
  logic [LANES-1:0][ACC_W-1:0] lane_acc;
  logic [LANES-1:0]            lane_en_q;

  assign beat_s0   = pixel_valid & ~start;
  assign upd_s1    = ctl_s1.beat & ~start;
  assign pass_done = ctl_s1.last & ~start;

  mad_chip_delay #(.PIX_W(PIX_W), .DEPTH(TAPS)) i_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start),
    .shift (beat_s0),
    .din   (chip_px),
    .taps  (chip_tap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_s1 <= '0;
    end else begin
      ctl_s1.beat <= beat_s0;
      ctl_s1.last <= beat_s0 & last_pixel;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    mad_lane #(.PIX_W(PIX_W), .ACC_W(ACC_W)) i_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .load  (beat_s0),
      .upd   (upd_s1),
      .tmpl  (tmpl_px),
      .chip  (chip_tap[k]),
      .acc   (lane_acc[k])
    );
    assign scores[k*ACC_W +: ACC_W] = lane_en_q[k] ? lane_acc[k] : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_en_q <= '1;
      score_row <= '0;
    end else if (start) begin
      lane_en_q <= lane_en;
      score_row <= row_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scores_valid <= 1'b0;
    else        scores_valid <= pass_done;
  end

endmodule

// File: rtl/mad_dither_checker.sv
module mad_dither_checker #(
  parameter int LANES = 11,
  parameter int ACC_W = 24,
  parameter int ROW_W = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start,
  input logic                        pixel_valid,
  input logic                        last_pixel,
  input logic                        upd_s1,
  input logic [LANES-1:0]            lane_en,
  input logic [ROW_W-1:0]            row_idx,
  input logic [LANES-1:0][ACC_W-1:0] lane_acc,
  input logic [LANES*ACC_W-1:0]      scores,
  input logic                        scores_valid,
  input logic [ROW_W-1:0]            score_row
);

  // R5
  pulse_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scores_valid |-> $past(pixel_valid && last_pixel && !start, 2));

  // R7
  row_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> score_row == $past(row_idx));

  // R7
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(score_row));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    // R8
    clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> lane_acc[k] == '0);

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> lane_acc[k] >= $past(lane_acc[k]));

    // R6
    masked_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !lane_en[k]) |=> scores[k*ACC_W +: ACC_W] == '1);

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !upd_s1) |=> $stable(lane_acc[k]));
  end

endmodule

bind mad_dither_element mad_dither_checker #(
  .LANES(LANES), .ACC_W(ACC_W), .ROW_W(ROW_W)
) i_mad_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .pixel_valid  (pixel_valid),
  .last_pixel   (last_pixel),
  .upd_s1       (upd_s1),
  .lane_en      (lane_en),
  .row_idx      (row_idx),
  .lane_acc     (lane_acc),
  .scores       (scores),
  .scores_valid (scores_valid),
  .score_row    (score_row)
);

// File: tb/test_mad_dither_element.sv
module test_mad_dither_element;
  localparam int LANES = 11;
  localparam int PIX_W = 12;
  localparam int ACC_W = 24;
  localparam int ROW_W = 4;
  localparam longint SAT = (64'd1 << ACC_W) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rst_n, start, pixel_valid, last_pixel;
  logic [PIX_W-1:0]       tmpl_px, chip_px;
  logic [ROW_W-1:0]       row_idx;
  logic [LANES-1:0]       lane_en;
  logic                   scores_valid;
  logic [LANES*ACC_W-1:0] scores;
  logic [ROW_W-1:0]       score_row;

  mad_dither_element i_mad_dither_element (
    .clk(clk), .rst_n(rst_n), .start(start), .pixel_valid(pixel_valid),
    .last_pixel(last_pixel), .tmpl_px(tmpl_px), .chip_px(chip_px),
    .row_idx(row_idx), .lane_en(lane_en), .scores_valid(scores_valid),
    .scores(scores), .score_row(score_row)
  );

  int checks = 0;
  int errors = 0;
  int tq[$];
  int cq[$];
  logic [LANES-1:0] en_m;
  int row_m;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference score: lane k pairs template n with chip n-k, zero before pass.
  function automatic longint ref_score(int k);
    longint s = 0;
    if (!en_m[k]) return SAT;
    for (int n = 0; n < tq.size(); n++) begin
      int c = (n >= k) ? cq[n-k] : 0;
      int d = tq[n] - c;
      s += (d < 0) ? -d : d;
    end
    return (s > SAT) ? SAT : s;
  endfunction

  function automatic longint lane_out(int k);
    return longint'(scores[k*ACC_W +: ACC_W]);
  endfunction

  task automatic begin_pass(int row, logic [LANES-1:0] en);
    start = 1'b1; row_idx = row[ROW_W-1:0]; lane_en = en;
    @(negedge clk);
    start = 1'b0; pixel_valid = 1'b0;
    tq.delete(); cq.delete(); en_m = en; row_m = row;
  endtask

  task automatic beat(int t, int c, bit last);
    pixel_valid = 1'b1; last_pixel = last;
    tmpl_px = t[PIX_W-1:0]; chip_px = c[PIX_W-1:0];
    tq.push_back(t); cq.push_back(c);
    @(negedge clk);
    pixel_valid = 1'b0; last_pixel = 1'b0;
  endtask

  function automatic int rnd_px();
    return int'($urandom % 4096) - 2048;
  endfunction

  task automatic rand_beats(int n, int gap_pct);
    for (int i = 0; i < n; i++) begin
      if (int'($urandom % 100) < gap_pct) @(negedge clk);
      beat(rnd_px(), rnd_px(), i == n - 1);
    end
  endtask

  task automatic finish_check(string tag);
    @(negedge clk);
    chk(scores_valid === 1'b1, "R5 pulse in second cycle", scores_valid, 1);
    for (int k = 0; k < LANES; k++)
      chk(lane_out(k) == ref_score(k), {tag, " lane score"}, lane_out(k), ref_score(k));
    chk(score_row == row_m, "R7 row index", score_row, row_m);
    @(negedge clk);
    chk(scores_valid === 1'b0, "R5 single cycle pulse", scores_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; pixel_valid = 1'b0; last_pixel = 1'b0;
    tmpl_px = '0; chip_px = '0; row_idx = '0; lane_en = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(scores_valid === 1'b0, "R1 valid after reset", scores_valid, 0);
    chk(score_row == 0, "R1 row after reset", score_row, 0);
    for (int k = 0; k < LANES; k++)
      chk(lane_out(k) == 0, "R1 score after reset", lane_out(k), 0);

    // R3 extreme signed operands
    begin_pass(1, '1);
    for (int i = 0; i < 20; i++) beat(2047, -2048, i == 19);
    finish_check("R3 extremes");

    // R2 / R7 random passes, back to back, several rows
    for (int r = 0; r < 4; r++) begin
      begin_pass(r + 2, '1);
      rand_beats(30 + r * 7, 0);
      finish_check("R2 random");
    end

    // R9 random pass with idle gaps
    begin_pass(9, '1);
    rand_beats(40, 40);
    finish_check("R9 gaps");

    // R6 seven active lanes, four masked
    begin_pass(5, 11'b000_0111_1111);
    rand_beats(25, 10);
    finish_check("R6 masked");

    // R10 hold after pulse
    begin
      longint held[LANES];
      for (int k = 0; k < LANES; k++) held[k] = lane_out(k);
      repeat (6) @(negedge clk);
      chk(scores_valid === 1'b0, "R10 no repeat pulse", scores_valid, 0);
      for (int k = 0; k < LANES; k++)
        chk(lane_out(k) == held[k], "R10 hold", lane_out(k), held[k]);
    end

    // R8 restart mid pass, beat in start cycle discarded
    begin_pass(3, '1);
    rand_beats(6, 0);
    for (int i = 0; i < 5; i++) beat(rnd_px(), rnd_px(), 1'b0);
    start = 1'b1; row_idx = 4'd12; lane_en = '1;
    pixel_valid = 1'b1; tmpl_px = 12'h800; chip_px = 12'h7FF;
    @(negedge clk);
    start = 1'b0; pixel_valid = 1'b0;
    tq.delete(); cq.delete(); en_m = '1; row_m = 12;
    rand_beats(15, 20);
    finish_check("R8 restart");

    // R4 saturation on a long pass
    begin_pass(15, '1);
    for (int i = 0; i < 4200; i++) beat(2047, -2048, i == 4199);
    finish_check("R4 saturation");
    chk(lane_out(0) == SAT, "R4 lane0 clamp", lane_out(0), SAT);

    // R2 small pass shorter than the delay line
    begin_pass(0, '1);
    rand_beats(4, 0);
    finish_check("R2 short");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule